// File: doc/BRIEF.md
# Two-Level Interrupt Priority Arbiter

This block chooses one interrupt among a set of on-chip sources. Software gives each source a 5-bit priority through a simple write port. On every cycle the block compares all pending sources with a non-masked priority at full 5-bit resolution. It breaks exact ties with a fixed order of sources and registers the result for the CPU.

The CPU does not see the 5-bit value. It sees a 4-bit level formed by dropping the least significant bit of the winner's priority. Two sources can therefore look equal to the CPU while the block still orders them. A request is raised only when that level is strictly above the CPU's current 4-bit mask. When the CPU acknowledges, the block captures a unique event code for the winning source, and software uses that code to branch to the right handler.

Top module: `intc_prio_arb`

## Requirements
- R1: After reset, `irq_req_o` is 0, `irq_lvl_o` is 0, `evt_code_o` is 0, and every source priority is 0.
- R2: Among the pending sources whose priority is 0x02 or more, the winner is the one with the largest 5-bit priority.
- R3: `irq_lvl_o` equals the winner's 5-bit priority shifted right by one (bits 4:1). It is 0 when no source qualifies.
- R4: When two pending sources share a 4-bit level but differ at 5 bits (for example 0x1A and 0x1B, both level 0xD), the source with the larger 5-bit value wins.
- R5: When pending sources have identical 5-bit priorities, the source with the lowest index wins.
- R6: A source with priority 0x00 or 0x01 never wins and never causes a request.
- R7: `irq_req_o` is 1 only when the winner's 4-bit level is strictly greater than `cpu_mask_i`.
- R8: The event code of source i is 0x400 + 0x20*i, 12 bits wide. `evt_code_o` loads the code of the registered winner on a clock edge where `ack_i` is 1 and `irq_req_o` is 1. On any other edge it holds its value.
- R9: Pending inputs are level-sensitive. `irq_req_o` and `irq_lvl_o` reflect the inputs of the previous clock edge, so a source that drops out is no longer reported one cycle later.
- R10: A priority write (`prio_wr_en`, `prio_wr_idx`, `prio_wr_data`) takes effect at the clock edge where it is presented. Its effect on the outputs appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_wr_en | input | 1 | Priority write strobe |
| prio_wr_idx | input | 4 | Source index to write |
| prio_wr_data | input | 5 | New 5-bit priority |
| pend_i | input | 16 | Level-sensitive pending flags, one per source |
| cpu_mask_i | input | 4 | CPU's current interrupt mask level |
| ack_i | input | 1 | CPU acknowledge; loads the event register |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_lvl_o | output | 4 | Rounded 4-bit level of the winner |
| evt_code_o | output | 12 | Event code of the last acknowledged source |

## Verification
The bench sets up priority pairs that round to the same level, such as 0x1A and 0x1B. A design that compared only 4-bit levels would hand the event code to the lower-indexed source. It programs identical priorities to check that the lower index wins, since a reversed tree would pick the higher one. It drives a level exactly equal to the mask and a maximal mask, where an off-by-one compare would raise a spurious request. It also checks sources at 0x01 and 0x00, which a design that tested only for zero would let through, and it acknowledges with no request pending and moves the winner without an acknowledge, where a loosely enabled event register would change.

// File: rtl/intc_arb_pkg.sv
package intc_arb_pkg;
    localparam int PRIO_W = 5;
    localparam int LVL_W  = 4;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    // Drop the least significant bit to get the CPU-visible level.
    function automatic lvl_t prio_to_lvl(prio_t p);
        return p[PRIO_W-1:1];
    endfunction
endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs
    import intc_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [PRIO_W-1:0]             wr_data,
    output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o
);
    logic [N_SRC-1:0][PRIO_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (int'(wr_idx) < N_SRC)) begin
            regs_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign prio_o = regs_q;
endmodule

// File: rtl/intc_prio_tree.sv
module intc_prio_tree
    import intc_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [N_SRC-1:0]             pend_i,
    output logic                         win_vld_o,
    output logic [PRIO_W-1:0]            win_prio_o,
    output logic [IDX_W-1:0]             win_idx_o
);
    localparam int LEAVES = 1 << $clog2(N_SRC);
    localparam int NODES  = 2 * LEAVES;

    logic                  leaf_vld  [LEAVES];
    prio_t                 leaf_prio [LEAVES];
    logic [IDX_W-1:0]      leaf_idx  [LEAVES];

    // Leaves: a source qualifies when pending and its level is non-zero.
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < N_SRC) begin : g_real
            assign leaf_vld[j]  = pend_i[j] && (prio_to_lvl(prio_i[j]) != '0);
            assign leaf_prio[j] = prio_i[j];
            assign leaf_idx[j]  = IDX_W'(j);
        end else begin : g_pad
            assign leaf_vld[j]  = 1'b0;
            assign leaf_prio[j] = '0;
            assign leaf_idx[j]  = '0;
        end
    end

    logic             nd_vld  [1:NODES-1];
    prio_t            nd_prio [1:NODES-1];
    logic [IDX_W-1:0] nd_idx  [1:NODES-1];

    // Node i has children 2i (lower indices) and 2i+1; the left child keeps ties.
    always_comb begin
        for (int j = 0; j < LEAVES; j++) begin
            nd_vld[LEAVES+j]  = leaf_vld[j];
            nd_prio[LEAVES+j] = leaf_prio[j];
            nd_idx[LEAVES+j]  = leaf_idx[j];
        end
        for (int i = LEAVES - 1; i >= 1; i--) begin
            if (nd_vld[2*i+1] && (!nd_vld[2*i] || (nd_prio[2*i+1] > nd_prio[2*i]))) begin
                nd_vld[i]  = 1'b1;
                nd_prio[i] = nd_prio[2*i+1];
                nd_idx[i]  = nd_idx[2*i+1];
            end else begin
                nd_vld[i]  = nd_vld[2*i];
                nd_prio[i] = nd_prio[2*i];
                nd_idx[i]  = nd_idx[2*i];
            end
        end
    end

    assign win_vld_o  = nd_vld[1];
    assign win_prio_o = nd_prio[1];
    assign win_idx_o  = nd_idx[1];
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
    import intc_arb_pkg::*;
#(
    parameter int N_SRC     = 16,
    parameter int IDX_W     = $clog2(N_SRC),
    parameter int CODE_W    = 12,
    parameter int CODE_BASE = 'h400,
    parameter int CODE_STEP = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_wr_en,
    input  logic [IDX_W-1:0]  prio_wr_idx,
    input  logic [PRIO_W-1:0] prio_wr_data,
    input  logic [N_SRC-1:0]  pend_i,
    input  logic [LVL_W-1:0]  cpu_mask_i,
    input  logic              ack_i,
    output logic              irq_req_o,
    output logic [LVL_W-1:0]  irq_lvl_o,
    output logic [CODE_W-1:0] evt_code_o
);
    typedef struct packed {
        logic              req;
        lvl_t              lvl;
        logic [IDX_W-1:0]  idx;
        logic [CODE_W-1:0] evt;
    } state_t;

    function automatic logic [CODE_W-1:0] code_of(logic [IDX_W-1:0] idx);
        return CODE_W'(CODE_BASE + CODE_STEP * int'(idx));
    endfunction

    logic [N_SRC-1:0][PRIO_W-1:0] prio_tab;
    logic                         win_vld;
    prio_t                        win_prio;
    logic [IDX_W-1:0]             win_idx;
    state_t                       st_d, st_q;

    intc_prio_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prio_wr_en),
        .wr_idx  (prio_wr_idx),
        .wr_data (prio_wr_data),
        .prio_o  (prio_tab)
    );

    intc_prio_tree #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_tree (
        .prio_i     (prio_tab),
        .pend_i     (pend_i),
        .win_vld_o  (win_vld),
        .win_prio_o (win_prio),
        .win_idx_o  (win_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.lvl = win_vld ? prio_to_lvl(win_prio) : '0;
        st_d.req = win_vld && (prio_to_lvl(win_prio) > cpu_mask_i);
        st_d.idx = win_vld ? win_idx : '0;
        // Event register captures the winner the CPU was shown.
        if (ack_i && st_q.req) begin
            st_d.evt = code_of(st_q.idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req_o  = st_q.req;
    assign irq_lvl_o  = st_q.lvl;
    assign evt_code_o = st_q.evt;
endmodule

// File: rtl/intc_prio_arb_chk.sv
module intc_prio_arb_chk #(
    parameter int N_SRC  = 16,
    parameter int LVL_W  = 4,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  pend_i,
    input logic [LVL_W-1:0]  cpu_mask_i,
    input logic              ack_i,
    input logic              irq_req_o,
    input logic [LVL_W-1:0]  irq_lvl_o,
    input logic [CODE_W-1:0] evt_code_o
);
    AST_REQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_lvl_o > $past(cpu_mask_i))); // R7

    AST_FULL_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mask_i == '1) |=> !irq_req_o); // R7

    AST_REQ_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_lvl_o != '0)); // R6

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> (!irq_req_o && (irq_lvl_o == '0))); // R9

    AST_EVT_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> $stable(evt_code_o)); // R8

    AST_EVT_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_req_o) |=> $stable(evt_code_o)); // R8
endmodule

bind intc_prio_arb intc_prio_arb_chk #(
    .N_SRC  (N_SRC),
    .LVL_W  (intc_arb_pkg::LVL_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend_i),
    .cpu_mask_i (cpu_mask_i),
    .ack_i      (ack_i),
    .irq_req_o  (irq_req_o),
    .irq_lvl_o  (irq_lvl_o),
    .evt_code_o (evt_code_o)
);

// File: tb/tb_intc_prio_arb.sv
module tb_intc_prio_arb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prio_wr_en = 1'b0;
    logic [3:0]  prio_wr_idx = '0;
    logic [4:0]  prio_wr_data = '0;
    logic [N-1:0] pend_i = '0;
    logic [3:0]  cpu_mask_i = '0;
    logic        ack_i = 1'b0;
    logic        irq_req_o;
    logic [3:0]  irq_lvl_o;
    logic [11:0] evt_code_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [11:0] exp_evt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_prio_arb dut (
        .clk(clk), .rst_n(rst_n),
        .prio_wr_en(prio_wr_en), .prio_wr_idx(prio_wr_idx), .prio_wr_data(prio_wr_data),
        .pend_i(pend_i), .cpu_mask_i(cpu_mask_i), .ack_i(ack_i),
        .irq_req_o(irq_req_o), .irq_lvl_o(irq_lvl_o), .evt_code_o(evt_code_o)
    );

    function automatic logic [11:0] code(int idx);
        return 12'(32'h400 + 32'h20 * idx);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic set_prio(int idx, logic [4:0] val);
        @(negedge clk);
        prio_wr_en = 1'b1; prio_wr_idx = 4'(idx); prio_wr_data = val;
        @(negedge clk);
        prio_wr_en = 1'b0;
    endtask

    task automatic clear_all();
        pend_i = '0;
        for (int i = 0; i < N; i++) set_prio(i, 5'h00);
    endtask

    // Apply pending/mask, check outputs one edge later, then acknowledge.
    task automatic run_case(string tag, logic [N-1:0] pend, logic [3:0] mask,
                            logic exp_req, logic [3:0] exp_lvl, int exp_idx);
        pend_i = pend; cpu_mask_i = mask;
        @(negedge clk);
        chk({tag, " req"}, 32'(irq_req_o), 32'(exp_req));
        chk({tag, " lvl"}, 32'(irq_lvl_o), 32'(exp_lvl));
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        if (exp_req) exp_evt = code(exp_idx);
        chk({tag, " evt"}, 32'(evt_code_o), 32'(exp_evt));
    endtask

    task automatic t_reset();
        chk("R1 req after reset", 32'(irq_req_o), 0);
        chk("R1 lvl after reset", 32'(irq_lvl_o), 0);
        chk("R1 evt after reset", 32'(evt_code_o), 0);
        run_case("R1 all pending, priorities zero", '1, 4'h0, 1'b0, 4'h0, 0);
    endtask

    task automatic t_greatest();
        clear_all();
        set_prio(3, 5'h08); set_prio(7, 5'h12); set_prio(10, 5'h0C);
        run_case("R2 R3 greatest of three", N'((1 << 3) | (1 << 7) | (1 << 10)),
                 4'h0, 1'b1, 4'h9, 7);
    endtask

    task automatic t_round_tie();
        clear_all();
        set_prio(2, 5'h1A); set_prio(9, 5'h1B);
        run_case("R4 0x1A vs 0x1B", N'((1 << 2) | (1 << 9)), 4'h0, 1'b1, 4'hD, 9);
    endtask

    task automatic t_exact_tie();
        clear_all();
        set_prio(4, 5'h14); set_prio(11, 5'h14);
        run_case("R5 equal priority low index", N'((1 << 4) | (1 << 11)), 4'h0, 1'b1, 4'hA, 4);
    endtask

    task automatic t_masked_low();
        clear_all();
        set_prio(5, 5'h01); set_prio(6, 5'h00); set_prio(12, 5'h02);
        run_case("R6 only 0x01 and 0x00", N'((1 << 5) | (1 << 6)), 4'h0, 1'b0, 4'h0, 0);
        run_case("R6 0x02 beats 0x01", N'((1 << 5) | (1 << 12)), 4'h0, 1'b1, 4'h1, 12);
    endtask

    task automatic t_mask();
        clear_all();
        set_prio(1, 5'h10);
        run_case("R7 level equals mask", N'(1 << 1), 4'h8, 1'b0, 4'h8, 0);
        run_case("R7 level above mask", N'(1 << 1), 4'h7, 1'b1, 4'h8, 1);
        set_prio(1, 5'h1F);
        run_case("R7 mask 0xF blocks 0x1F", N'(1 << 1), 4'hF, 1'b0, 4'hF, 0);
    endtask

    task automatic t_level();
        clear_all();
        set_prio(3, 5'h08); set_prio(7, 5'h12);
        run_case("R9 both pending", N'((1 << 3) | (1 << 7)), 4'h0, 1'b1, 4'h9, 7);
        run_case("R9 winner drops", N'(1 << 3), 4'h0, 1'b1, 4'h4, 3);
        run_case("R9 all drop", '0, 4'h0, 1'b0, 4'h0, 0);
    endtask

    task automatic t_evt_hold();
        clear_all();
        set_prio(8, 5'h0A); set_prio(13, 5'h1C);
        run_case("R8 capture source 8", N'(1 << 8), 4'h0, 1'b1, 4'h5, 8);
        pend_i = N'(1 << 13);
        @(negedge clk);
        @(negedge clk);
        chk("R8 winner moved without ack", 32'(evt_code_o), 32'(code(8)));
        chk("R8 new winner level", 32'(irq_lvl_o), 32'h0E);
        run_case("R8 ack loads source 13", N'(1 << 13), 4'h0, 1'b1, 4'hE, 13);
    endtask

    task automatic t_write();
        clear_all();
        set_prio(3, 5'h08);
        pend_i = N'(1 << 3); cpu_mask_i = 4'h0;
        @(negedge clk);
        chk("R10 before write", 32'(irq_lvl_o), 32'h4);
        set_prio(3, 5'h1E);
        chk("R10 write not yet visible", 32'(irq_lvl_o), 32'h4);
        @(negedge clk);
        chk("R10 write visible", 32'(irq_lvl_o), 32'hF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_greatest();
        t_round_tie();
        t_exact_tie();
        t_masked_low();
        t_mask();
        t_level();
        t_evt_hold();
        t_write();
        finish_run();
    end
endmodule